// File: doc/BRIEF.md
# Truncation-Selection Evolution Controller

This block runs a mutation-only evolutionary search around an external fitness evaluator. A genome describes a one-row feed-forward gate network. Each node has two connection genes and one function gene, and one final gene names the node or circuit input that drives the output. The controller keeps a ranked set of four elite genomes. A generation is built by cycling through the four parents in rank order, each time copying the parent and rewriting one gene chosen at random. The rewritten gene always gets a legal value that differs from the old one. Each mutant goes to the evaluator over a valid/ready request channel, and the evaluator answers with a single-cycle fitness strobe.

Each returned fitness is merged into a working copy of the elite set. At the end of a generation that copy becomes the parent set for the next generation. A generation in which the top fitness does not rise strictly counts as stagnant. The run keeps going after a perfect score, because the evaluator may still reward smaller circuits. It finishes only after a parameterised number of consecutive stagnant generations. A 32-bit Galois shift register with a nonzero seed supplies gene positions and new values.

Top module: `evo_ctrl`

## Requirements
- R1: After reset, `done` and `req_valid` are low, `best_fitness` and `best_genome` are zero, and no request appears until `start` is pulsed.
- R2: Every requested genome differs from its parent in exactly one gene (genes are GW-bit fields, gene k at bits [k*GW +: GW]).
- R3: Every gene of every requested genome obeys the connectivity rule. For node n (genes 3n and 3n+1) a connection value is below NUM_IN+n. A function gene (3n+2) is below NUM_FN. The output gene (index 3*NUM_NODES) is below NUM_IN+NUM_NODES.
- R4: Request i of a generation (counting from 0) is a mutant of committed parent slot i mod NPAR, where slot 0 holds the highest fitness.
- R5: A generation issues exactly POP requests. While `req_ready` is low, `req_valid` and `req_genome` stay unchanged.
- R6: After each result, the working set holds the NPAR best of its previous entries and the new mutant, ranked by descending fitness. A mutant whose fitness equals an entry's ranks ahead of that entry.
- R7: Two cycles after a generation's last result, `best_fitness` and `best_genome` show slot 0 of the newly committed set.
- R8: A generation whose top fitness is not strictly above the previous top raises the stagnation count by one; otherwise the count returns to zero. When the count reaches STALL_LIMIT, `done` rises. It then stays high and no further requests are issued.
- R9: Reaching any fitness value, including the maximum, does not end the run. Only the stagnation count does.
- R10: `start` has no effect while a run is in progress. When idle or finished, it clears the elite and parent sets to the all-zero genome with fitness 0 and starts a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle or finished |
| req_valid | output | 1 | Mutant genome is offered to the evaluator |
| req_ready | input | 1 | Evaluator accepts the offered genome |
| req_genome | output | GENOME_W | Mutant genome being offered |
| res_valid | input | 1 | Single-cycle fitness strobe from the evaluator |
| res_fitness | input | FW | Fitness of the last accepted genome |
| best_genome | output | GENOME_W | Top-ranked committed genome |
| best_fitness | output | FW | Fitness of the top-ranked committed genome |
| done | output | 1 | Run finished by stagnation |

## Verification
A request becomes visible two clock edges after the accepted `start` or after a mid-generation result: one edge to build the mutant, one to offer it. After a generation's last result, the committed set, the best outputs and `done` all change on the second edge, and the next request follows one edge later. The bench samples on falling edges and polls each expected event with a bound. It checks the best outputs when the first request of a generation appears and `done` within a few cycles after the final result. A reference model of the ranked set, fed from the bench's own fitness function, supplies every expected parent and best value through a queue.

// File: rtl/evo_pkg.sv
package evo_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_MUT, S_REQ, S_WAIT, S_COMMIT, S_DONE
  } evo_state_t;

  // bits needed for the widest gene value range
  function automatic int gene_bits(input int num_in, input int num_nodes, input int num_fn);
    int span;
    span = (num_in + num_nodes > num_fn) ? num_in + num_nodes : num_fn;
    return $clog2(span);
  endfunction

  // number of legal values for gene k
  function automatic int gene_limit(input int k, input int num_in,
                                    input int num_nodes, input int num_fn);
    if (k >= 3 * num_nodes) return num_in + num_nodes;
    if (k % 3 == 2)         return num_fn;
    return num_in + k / 3;
  endfunction

  // one step of a right-shifting Galois register, taps 32,22,2,1
  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
  endfunction

endpackage

// File: rtl/evo_lfsr.sv
module evo_lfsr import evo_pkg::*; #(
  parameter logic [31:0] SEED = 32'h1D2C_3B4A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  output logic [31:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= lfsr_next(state);
  end
endmodule

// File: rtl/evo_mutator.sv
module evo_mutator import evo_pkg::*; #(
  parameter int NUM_IN    = 5,
  parameter int NUM_NODES = 8,
  parameter int NUM_FN    = 4,
  parameter int GW        = 4,
  parameter int NGENES    = 3 * NUM_NODES + 1,
  localparam int GENOME_W = NGENES * GW
) (
  input  logic [GENOME_W-1:0] parent,
  input  logic [31:0]         rnd,
  output logic [GENOME_W-1:0] child
);
  int pos, lim, old_v, new_v;

  always_comb begin
    pos   = int'(rnd[15:0]) % NGENES;
    lim   = gene_limit(pos, NUM_IN, NUM_NODES, NUM_FN);
    old_v = int'(parent[pos*GW +: GW]);
    // offset 1..lim-1 guarantees a different, still legal value
    new_v = (old_v + 1 + int'(rnd[31:16]) % (lim - 1)) % lim;
    child = parent;
    child[pos*GW +: GW] = GW'(new_v);
  end
endmodule

// File: rtl/evo_elite.sv
module evo_elite #(
  parameter int GENOME_W = 100,
  parameter int FW       = 16,
  parameter int NPAR     = 4,
  localparam int PW      = $clog2(NPAR + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic                           ins,
  input  logic [GENOME_W-1:0]            ins_g,
  input  logic [FW-1:0]                  ins_f,
  input  logic                           commit,
  output logic [NPAR-1:0][FW-1:0]        el_f,
  output logic [NPAR-1:0][GENOME_W-1:0]  par_g,
  output logic [NPAR-1:0][FW-1:0]        par_f
);
  logic [NPAR-1:0][GENOME_W-1:0] el_g, nxt_g;
  logic [NPAR-1:0][FW-1:0]       nxt_f;
  logic [NPAR-1:0]               above;
  logic [PW-1:0]                 slot;

  // entries strictly better than the newcomer keep their place
  always_comb begin
    for (int s = 0; s < NPAR; s++) above[s] = el_f[s] > ins_f;
    slot = PW'($countones(above));
  end

  for (genvar s = 0; s < NPAR; s++) begin : g_slot
    if (s == 0) begin : g_head
      assign nxt_g[s] = (slot == 0) ? ins_g : el_g[s];
      assign nxt_f[s] = (slot == 0) ? ins_f : el_f[s];
    end else begin : g_tail
      assign nxt_g[s] = (slot > PW'(s)) ? el_g[s] : (slot == PW'(s)) ? ins_g : el_g[s-1];
      assign nxt_f[s] = (slot > PW'(s)) ? el_f[s] : (slot == PW'(s)) ? ins_f : el_f[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      el_g  <= '0;
      el_f  <= '0;
      par_g <= '0;
      par_f <= '0;
    end else begin
      if (ins) begin
        el_g <= nxt_g;
        el_f <= nxt_f;
      end
      if (commit) begin
        par_g <= el_g;
        par_f <= el_f;
      end
    end
  end
endmodule

// File: rtl/evo_ctrl.sv
module evo_ctrl import evo_pkg::*; #(
  parameter int          NUM_IN      = 5,
  parameter int          NUM_NODES   = 8,
  parameter int          NUM_FN      = 4,
  parameter int          POP         = 128,
  parameter int          NPAR        = 4,
  parameter int          STALL_LIMIT = 50000,
  parameter int          FW          = 16,
  parameter logic [31:0] SEED        = 32'h1D2C_3B4A,
  localparam int         NGENES      = 3 * NUM_NODES + 1,
  localparam int         GW          = gene_bits(NUM_IN, NUM_NODES, NUM_FN),
  localparam int         GENOME_W    = NGENES * GW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [GENOME_W-1:0] req_genome,
  input  logic                res_valid,
  input  logic [FW-1:0]       res_fitness,
  output logic [GENOME_W-1:0] best_genome,
  output logic [FW-1:0]       best_fitness,
  output logic                done
);
  localparam int IDX_W   = $clog2(POP);
  localparam int STALL_W = $clog2(STALL_LIMIT + 1);
  localparam int PSEL_W  = $clog2(NPAR);

  evo_state_t                    state;
  logic [IDX_W-1:0]              idx;
  logic [STALL_W-1:0]            stall, stall_next;
  logic [GENOME_W-1:0]           cand, cand_parent, child;
  logic [31:0]                   lfsr_state;
  logic [NPAR-1:0][FW-1:0]       el_f, par_f;
  logic [NPAR-1:0][GENOME_W-1:0] par_g;

  // named events
  logic ev_start, ev_issue, ev_result, ev_last, ev_commit, improved;
  assign ev_start  = start && (state == S_IDLE || state == S_DONE);
  assign ev_issue  = state == S_MUT;
  assign ev_result = state == S_WAIT && res_valid;
  assign ev_last   = ev_result && idx == IDX_W'(POP - 1);
  assign ev_commit = state == S_COMMIT;
  assign improved  = el_f[0] > par_f[0];
  assign stall_next = improved ? '0 : stall + 1'b1;

  assign cand_parent = par_g[idx[PSEL_W-1:0]];

  evo_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(ev_issue), .state(lfsr_state)
  );

  evo_mutator #(.NUM_IN(NUM_IN), .NUM_NODES(NUM_NODES), .NUM_FN(NUM_FN),
                .GW(GW), .NGENES(NGENES)) u_mut (
    .parent(cand_parent), .rnd(lfsr_state), .child(child)
  );

  evo_elite #(.GENOME_W(GENOME_W), .FW(FW), .NPAR(NPAR)) u_elite (
    .clk(clk), .rst_n(rst_n), .clear(ev_start),
    .ins(ev_result), .ins_g(cand), .ins_f(res_fitness),
    .commit(ev_commit), .el_f(el_f), .par_g(par_g), .par_f(par_f)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      stall <= '0;
      cand  <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start) begin
          state <= S_MUT;
          idx   <= '0;
          stall <= '0;
        end
        S_MUT: begin
          cand  <= child;
          state <= S_REQ;
        end
        S_REQ: if (req_ready) state <= S_WAIT;
        S_WAIT: if (res_valid) begin
          idx   <= idx + 1'b1;
          state <= ev_last ? S_COMMIT : S_MUT;
        end
        S_COMMIT: begin
          stall <= stall_next;
          idx   <= '0;
          state <= (stall_next == STALL_W'(STALL_LIMIT)) ? S_DONE : S_MUT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_valid    = state == S_REQ;
  assign req_genome   = cand;
  assign best_genome  = par_g[0];
  assign best_fitness = par_f[0];
  assign done         = state == S_DONE;
endmodule

// File: rtl/evo_ctrl_chk.sv
module evo_ctrl_chk import evo_pkg::*; #(
  parameter int NUM_IN    = 5,
  parameter int NUM_NODES = 8,
  parameter int NUM_FN    = 4,
  parameter int NPAR      = 4,
  parameter int FW        = 16,
  parameter int GW        = 4,
  parameter int NGENES    = 25,
  localparam int GENOME_W = NGENES * GW
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [GENOME_W-1:0]      req_genome,
  input logic [GENOME_W-1:0]      cand_parent,
  input logic                     done,
  input logic [NPAR-1:0][FW-1:0]  el_f,
  input logic [31:0]              lfsr_state
);
  function automatic int changed_genes(input logic [GENOME_W-1:0] a, b);
    int n = 0;
    for (int k = 0; k < NGENES; k++) if (a[k*GW +: GW] != b[k*GW +: GW]) n++;
    return n;
  endfunction

  function automatic bit all_legal(input logic [GENOME_W-1:0] g);
    for (int k = 0; k < NGENES; k++)
      if (int'(g[k*GW +: GW]) >= gene_limit(k, NUM_IN, NUM_NODES, NUM_FN)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit ranked(input logic [NPAR-1:0][FW-1:0] f);
    for (int s = 1; s < NPAR; s++) if (f[s] > f[s-1]) return 1'b0;
    return 1'b1;
  endfunction

  p_one_gene_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> changed_genes(req_genome, cand_parent) == 1);

  p_rng_alive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != 32'd0);

  p_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> all_legal(req_genome));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_genome));

  p_ranked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ranked(el_f));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
endmodule

bind evo_ctrl evo_ctrl_chk #(
  .NUM_IN(NUM_IN), .NUM_NODES(NUM_NODES), .NUM_FN(NUM_FN),
  .NPAR(NPAR), .FW(FW), .GW(GW), .NGENES(NGENES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
  .req_ready(req_ready), .req_genome(req_genome), .cand_parent(cand_parent),
  .done(done), .el_f(el_f), .lfsr_state(lfsr_state)
);

// File: tb/evo_ctrl_test.sv
module evo_ctrl_test;
  localparam int NUM_IN = 5, NUM_NODES = 8, NUM_FN = 4;
  localparam int POP = 16, NPAR = 4, STALL = 4, FW = 16;
  localparam int NGENES = 3 * NUM_NODES + 1;
  localparam int GW = 4;
  localparam int GENOME_W = NGENES * GW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic req_ready = 1'b0, res_valid = 1'b0;
  logic [FW-1:0] res_fitness = '0;
  logic req_valid, done;
  logic [GENOME_W-1:0] req_genome, best_genome;
  logic [FW-1:0] best_fitness;

  always #2 clk = ~clk;  // 250 MHz

  evo_ctrl #(.NUM_IN(NUM_IN), .NUM_NODES(NUM_NODES), .NUM_FN(NUM_FN),
             .POP(POP), .NPAR(NPAR), .STALL_LIMIT(STALL), .FW(FW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
    .req_ready(req_ready), .req_genome(req_genome), .res_valid(res_valid),
    .res_fitness(res_fitness), .best_genome(best_genome),
    .best_fitness(best_fitness), .done(done));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [GENOME_W-1:0] exp_q[$];
  logic [GENOME_W-1:0] m_par_g[NPAR], m_el_g[NPAR];
  int m_par_f[NPAR], m_el_f[NPAR];
  int m_stall;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // legal range of gene k, restated from the requirement text
  function automatic int legal_range(input int k);
    if (k == NGENES - 1) return NUM_IN + NUM_NODES;
    case (k % 3)
      2:       return NUM_FN;
      default: return NUM_IN + k / 3;
    endcase
  endfunction

  function automatic int gene(input logic [GENOME_W-1:0] g, input int k);
    return int'(g[k*GW +: GW]);
  endfunction

  function automatic int n_diff(input logic [GENOME_W-1:0] a, b);
    int c = 0;
    for (int k = 0; k < NGENES; k++) c += (gene(a, k) != gene(b, k)) ? 1 : 0;
    return c;
  endfunction

  function automatic bit is_legal(input logic [GENOME_W-1:0] g);
    bit ok = 1;
    for (int k = 0; k < NGENES; k++) if (gene(g, k) >= legal_range(k)) ok = 0;
    return ok;
  endfunction

  // bench evaluator: count of genes holding value 1
  function automatic int score(input logic [GENOME_W-1:0] g);
    int c = 0;
    for (int k = 0; k < NGENES; k++) if (gene(g, k) == 1) c++;
    return c;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NPAR; s++) begin
      m_par_g[s] = '0; m_el_g[s] = '0; m_par_f[s] = 0; m_el_f[s] = 0;
    end
    m_stall = 0;
    exp_q.delete();
  endtask

  task automatic model_insert(input logic [GENOME_W-1:0] g, input int f);
    int p = NPAR;
    for (int s = NPAR - 1; s >= 0; s--) if (m_el_f[s] <= f) p = s;
    for (int s = NPAR - 1; s > p; s--) begin
      m_el_g[s] = m_el_g[s-1]; m_el_f[s] = m_el_f[s-1];
    end
    if (p < NPAR) begin m_el_g[p] = g; m_el_f[p] = f; end
  endtask

  task automatic model_commit();
    if (m_el_f[0] > m_par_f[0]) m_stall = 0; else m_stall++;
    for (int s = 0; s < NPAR; s++) begin m_par_g[s] = m_el_g[s]; m_par_f[s] = m_el_f[s]; end
  endtask

  // driver: expected parent of every request in the coming generation
  task automatic push_gen_expect();
    for (int i = 0; i < POP; i++) exp_q.push_back(m_par_g[i % NPAR]);
  endtask

  // monitor + evaluator for one request
  task automatic serve(input int run, input int gen, input int i);
    logic [GENOME_W-1:0] g, par;
    int f;
    while (!req_valid) @(negedge clk);
    if (i == 0) begin
      chk(best_fitness == FW'(m_par_f[0]), "R7 best_fitness", best_fitness, m_par_f[0]);
      chk(best_genome == m_par_g[0], "R6 best_genome tie order", best_genome, m_par_g[0]);
      chk(done == 1'b0, "R9 run continues below stall limit", done, 0);
    end
    g = req_genome;
    par = exp_q.pop_front();
    chk(n_diff(g, par) <= 1, "R4 parent slot i mod NPAR", g, par);
    chk(n_diff(g, par) == 1, "R2 one gene changed", n_diff(g, par), 1);
    chk(is_legal(g), "R3 connectivity rule", g, 0);
    if (i % 5 == 2) begin
      if (run == 0 && gen == 1) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      if (run == 0 && gen == 1)
        chk(req_valid && req_genome == g, "R10 start ignored mid-run", req_genome, g);
      else
        chk(req_valid && req_genome == g, "R5 request held", req_genome, g);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    repeat (i % 3) @(negedge clk);
    f = score(g);
    res_valid = 1'b1;
    res_fitness = FW'(f);
    @(negedge clk);
    res_valid = 1'b0;
    model_insert(g, f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!req_valid && !done, "R1 idle after reset", {req_valid, done}, 0);
    end
    chk(best_fitness == 0 && best_genome == '0, "R1 best cleared", best_fitness, 0);

    for (int run = 0; run < 2; run++) begin
      int reqs;
      if (run == 1) chk(done == 1'b1, "R8 done before restart", done, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (run == 1)
        chk(!done && best_fitness == 0 && best_genome == '0, "R10 restart clears state",
            {done, best_fitness}, 0);
      model_reset();
      for (int gen = 0; gen < 400; gen++) begin
        push_gen_expect();
        reqs = 0;
        for (int i = 0; i < POP; i++) begin serve(run, gen, i); reqs++; end
        chk(reqs == POP, "R5 requests per generation", reqs, POP);
        model_commit();
        if (m_stall == STALL) begin
          for (int w = 0; w < 4 && !done; w++) @(negedge clk);
          chk(done == 1'b1, "R8 done after stagnation", done, 1);
          chk(best_fitness == FW'(m_par_f[0]), "R7 final best", best_fitness, m_par_f[0]);
          begin
            bit quiet = 1;
            for (int w = 0; w < 20; w++) begin
              @(negedge clk);
              if (req_valid || !done) quiet = 0;
            end
            chk(quiet, "R8 done holds with no requests", quiet, 1);
          end
          break;
        end
      end
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule